// File: doc/BRIEF.md
# Serial Peripheral Slave Byte Transceiver

This block is the slave end of a four-wire serial peripheral link. It swaps one 8-bit byte with an external master on each transfer. The master supplies the serial clock, the master-to-slave data line and an active-low select. The block drives the slave-to-master data line together with an output enable for the pad. Two configuration inputs set the idle level of the serial clock and which clock edge carries data. This covers all four clock modes.

On the system side, software writes the next byte into a transmit holding register through a write strobe. Each received byte appears on a parallel output with a one-cycle done pulse, and a read strobe acknowledges it. Two sticky flags report two faults: a transmit write that arrives while a byte is already in flight, and a received byte that replaces one that was never read. The serial clock, the data input and the select line each pass through a two-stage synchroniser. Every serial event is decoded in the system clock domain. The system clock must therefore run at least four times faster than the serial clock.

In phase-0 mode the falling edge of select starts each byte, so select must be toggled between bytes. In phase-1 mode the first clock edge starts a byte and select may stay low. A select-ignore option, honoured only in phase-1 mode, lets a single-slave system leave select unconnected.

Top module: `spi_slave_xcvr`

## Requirements
- R1: After reset, `spi_dout_oe`, `rx_done`, `late_err` and `ovr_err` are all 0.
- R2: `cfg_idle_hi` sets the serial clock idle level (0 = low, 1 = high). The leading edge is the transition away from idle and the trailing edge is the return to idle. With `cfg_phase`=0, data is captured on leading edges and shifted on trailing edges. With `cfg_phase`=1, data is shifted on leading edges and captured on trailing edges. Both data lines carry 8 bits, most significant bit first.
- R3: After the eighth capture edge, the received byte appears on `rx_data` and `rx_done` is high for exactly one system clock cycle.
- R4: With `cfg_phase`=0, a falling edge on `spi_sel_n` starts a byte. The most significant bit of the held transmit byte is on `spi_dout` before the first clock edge.
- R5: With `cfg_phase`=0, once a byte has completed, no further byte is received until `spi_sel_n` goes high and then low again. Clock edges in between leave `rx_data` and `rx_done` unchanged.
- R6: With `cfg_phase`=0, `sel_ignore` has no effect. While `spi_sel_n` is high, `spi_dout_oe` stays 0 and no byte is received.
- R7: With `cfg_phase`=1, the first leading edge while selected starts a byte. `spi_sel_n` may stay low across consecutive bytes. With `sel_ignore`=1, bytes are exchanged while `spi_sel_n` is high.
- R8: A `tx_wr` pulse loads `tx_data` into the holding register, and each byte sends the holding register's value at its start. A write after a byte has started and before it completes sets `late_err`. The current byte keeps its old value, and the new value goes out on the next byte.
- R9: While the slave is not selected (`spi_sel_n` high and the select-ignore option not in force), `spi_dout_oe` is 0 and a partial byte is discarded. The next byte is received whole.
- R10: `rx_rd` acknowledges the received byte. A completion while the previous byte is still unacknowledged sets `ovr_err`, and `rx_data` takes the new byte.
- R11: Driving `en` low clears `late_err` and `ovr_err`, abandons any byte in progress and forces `spi_dout_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low returns to idle and clears flags |
| cfg_idle_hi | input | 1 | Serial clock idle level |
| cfg_phase | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| sel_ignore | input | 1 | Treat slave as always selected (phase 1 only) |
| spi_clk | input | 1 | Serial clock from master |
| spi_din | input | 1 | Serial data from master |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_dout | output | 1 | Serial data to master |
| spi_dout_oe | output | 1 | Output enable for `spi_dout` |
| tx_data | input | DATA_W | Byte to load into the transmit holding register |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| rx_data | output | DATA_W | Last received byte |
| rx_done | output | 1 | One-cycle pulse on byte completion |
| rx_rd | input | 1 | Acknowledge of the received byte |
| late_err | output | 1 | Sticky: transmit write during a byte |
| ovr_err | output | 1 | Sticky: unacknowledged byte overwritten |

## Verification
The hardest states to reach from the ports are those that depend on where inside a byte something happens. Examples are a transmit write landing between the start edge and the last capture, or select rising after exactly half the bits. The bench drives the serial clock through a master model that can stop after any bit index. It can then inject a write or a select change at that boundary and resume the byte. Random bytes in random clock modes, some with select-ignore in phase 1, are mixed with these directed cuts.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

   // Serial events decoded in the system clock domain
   typedef struct packed {
      logic cap;     // capture a data bit
      logic shf;     // advance the outgoing bit
      logic start0;  // select falling edge (phase 0)
      logic sel;     // slave currently selected
   } spi_evt_t;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_slv_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("spi_slv_sync: W must be positive");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
   import spi_slv_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_idle_hi,
   input  logic     cfg_phase,
   input  logic     sel_ignore,
   input  logic     sclk_s,
   input  logic     seln_s,
   output spi_evt_t ev
);

   logic lvl, lvl_q, seln_q, lead, trail;

   // Level relative to idle: 1 means the clock is away from idle
   assign lvl = sclk_s ^ cfg_idle_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         seln_q <= 1'b1;
      end else begin
         lvl_q  <= lvl;
         seln_q <= seln_s;
      end
   end

   assign lead  = lvl & ~lvl_q;
   assign trail = ~lvl & lvl_q;

   always_comb begin
      ev.cap    = cfg_phase ? trail : lead;
      ev.shf    = cfg_phase ? lead  : trail;
      ev.start0 = ~cfg_phase & seln_q & ~seln_s;
      // the ignore option only counts in phase 1
      ev.sel    = ~seln_s | (cfg_phase & sel_ignore);
   end

endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
   import spi_slv_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cfg_phase,
   input  spi_evt_t          ev,
   input  logic              din_s,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_wr,
   input  logic              rx_rd,
   output logic              dout,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done,
   output logic              late_err,
   output logic              ovr_err
);

   localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

   logic [DATA_W-1:0] tx_hold, sh_tx, sh_rx;
   logic [DATA_W-1:0] rx_next;
   logic [CW-1:0]     cnt;
   logic              busy, rx_valid;

   assign rx_next = {sh_rx[DATA_W-2:0], din_s};
   assign dout    = sh_tx[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_hold  <= '0;
         sh_tx    <= '0;
         sh_rx    <= '0;
         rx_data  <= '0;
         cnt      <= '0;
         busy     <= 1'b0;
         rx_valid <= 1'b0;
         rx_done  <= 1'b0;
         late_err <= 1'b0;
         ovr_err  <= 1'b0;
      end else if (!en) begin
         cnt      <= '0;
         busy     <= 1'b0;
         rx_valid <= 1'b0;
         rx_done  <= 1'b0;
         late_err <= 1'b0;
         ovr_err  <= 1'b0;
         if (tx_wr) tx_hold <= tx_data;
      end else begin
         rx_done <= 1'b0;
         if (tx_wr) begin
            tx_hold <= tx_data;
            if (busy) late_err <= 1'b1;
         end
         if (rx_rd) rx_valid <= 1'b0;
         if (!ev.sel) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            if (ev.start0 || (cfg_phase && ev.shf && !busy)) begin
               busy  <= 1'b1;
               cnt   <= '0;
               sh_tx <= tx_hold;
            end else if (busy && ev.shf) begin
               sh_tx <= {sh_tx[DATA_W-2:0], 1'b0};
            end
            if (busy && ev.cap) begin
               sh_rx <= rx_next;
               if (cnt == LAST) begin
                  busy     <= 1'b0;
                  cnt      <= '0;
                  rx_data  <= rx_next;
                  rx_done  <= 1'b1;
                  rx_valid <= 1'b1;
                  if (rx_valid && !rx_rd) ovr_err <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   p_done_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> $past(ev.cap));

   p_start_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && !$past(cfg_phase)) |-> $past(ev.start0));

   p_late_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(late_err) |-> $past(tx_wr && busy));

   p_ovr_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_err) |-> $past(rx_valid));

endmodule

// File: rtl/spi_slave_xcvr.sv
module spi_slave_xcvr
   import spi_slv_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cfg_idle_hi,
   input  logic              cfg_phase,
   input  logic              sel_ignore,
   input  logic              spi_clk,
   input  logic              spi_din,
   input  logic              spi_sel_n,
   output logic              spi_dout,
   output logic              spi_dout_oe,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_wr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_done,
   input  logic              rx_rd,
   output logic              late_err,
   output logic              ovr_err
);

   generate
      if (DATA_W < 2) begin : g_bad_dw
         $error("spi_slave_xcvr: DATA_W must be at least 2");
      end
   endgenerate

   localparam int NSYNC = 3;

   logic [NSYNC-1:0] raw, synced;
   spi_evt_t         ev;

   assign raw = {spi_clk, spi_din, spi_sel_n};

   spi_slv_sync #(
      .W       (NSYNC),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b001)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (synced)
   );

   spi_slv_edge u_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_idle_hi (cfg_idle_hi),
      .cfg_phase   (cfg_phase),
      .sel_ignore  (sel_ignore),
      .sclk_s      (synced[2]),
      .seln_s      (synced[0]),
      .ev          (ev)
   );

   spi_slv_core #(
      .DATA_W (DATA_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .cfg_phase (cfg_phase),
      .ev        (ev),
      .din_s     (synced[1]),
      .tx_data   (tx_data),
      .tx_wr     (tx_wr),
      .rx_rd     (rx_rd),
      .dout      (spi_dout),
      .rx_data   (rx_data),
      .rx_done   (rx_done),
      .late_err  (late_err),
      .ovr_err   (ovr_err)
   );

   assign spi_dout_oe = en & ev.sel;

   p_flags_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (!late_err && !ovr_err && !rx_done));

endmodule

// File: tb/spi_slave_xcvr_tb_top.sv
module spi_slave_xcvr_tb_top;

   localparam int HP = 8;   // system clocks per serial half period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       ih = 1'b0, ph = 1'b0, sig = 1'b0;
   logic       sclk = 1'b0, din = 1'b0, seln = 1'b1;
   logic       dout, dout_oe;
   logic [7:0] txd = '0;
   logic       txw = 1'b0, rrd = 1'b0;
   logic [7:0] rxd;
   logic       rxdone, lerr, oerr;

   int errors = 0, checks = 0, done_cnt = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   spi_slave_xcvr dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_idle_hi(ih), .cfg_phase(ph),
      .sel_ignore(sig), .spi_clk(sclk), .spi_din(din), .spi_sel_n(seln),
      .spi_dout(dout), .spi_dout_oe(dout_oe), .tx_data(txd), .tx_wr(txw),
      .rx_data(rxd), .rx_done(rxdone), .rx_rd(rrd), .late_err(lerr),
      .ovr_err(oerr)
   );

   always @(posedge clk) if (rxdone) done_cnt <= done_cnt + 1;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_tx(input logic [7:0] v);
      txd = v; txw = 1'b1; tick(1); txw = 1'b0;
   endtask

   task automatic rd_ack();
      rrd = 1'b1; tick(1); rrd = 1'b0;
   endtask

   task automatic set_mode(input logic i_hi, input logic p);
      seln = 1'b1; sig = 1'b0; tick(4);
      ih = i_hi; ph = p; sclk = i_hi; tick(10);
   endtask

   // master model: bits from index hi down to lo
   task automatic run_bits(input logic [7:0] m, input int hi, input int lo,
                           inout logic [7:0] s);
      for (int i = hi; i >= lo; i--) begin
         if (!ph) begin
            din = m[i]; tick(HP);
            s[i] = dout; sclk = ~ih; tick(HP); sclk = ih;
         end else begin
            tick(HP); sclk = ~ih; din = m[i]; tick(HP);
            s[i] = dout; sclk = ih;
         end
      end
      tick(6);
   endtask

   function automatic logic [7:0] expect_byte(input logic [7:0] v);
      return v;
   endfunction

   initial begin
      int unsigned seed;
      logic [7:0] s, m, t, t2, hold;
      int d0;
      seed = $urandom(32'h1c3b);
      tick(3);
      // R1 reset state
      chk(dout_oe == 0, "R1 oe", dout_oe, 0);
      chk(rxdone == 0,  "R1 done", rxdone, 0);
      chk(lerr == 0 && oerr == 0, "R1 flags", {lerr, oerr}, 0);
      rst_n = 1'b1; en = 1'b1; tick(3);

      // random bytes in all four modes (R2, R3, R4, R7)
      for (int k = 0; k < 24; k++) begin
         logic use_ign;
         set_mode(1'($urandom), 1'($urandom));
         m = 8'($urandom); t = 8'($urandom);
         use_ign = ph & 1'($urandom);
         wr_tx(t);
         if (use_ign) sig = 1'b1; else seln = 1'b0;
         tick(6);
         d0 = done_cnt; s = '0;
         run_bits(m, 7, 0, s);
         chk(rxd == expect_byte(m), "R2 rx byte", rxd, m);
         chk(s == expect_byte(t), ph ? "R7 tx byte" : "R4 tx byte", s, t);
         chk(done_cnt == d0 + 1, "R3 done pulse", done_cnt, d0 + 1);
         seln = 1'b1; sig = 1'b0;
         rd_ack();
      end
      chk(lerr == 0, "R8 no late", lerr, 0);
      chk(oerr == 0, "R10 no overrun", oerr, 0);

      // R5 phase 0: no second byte without select toggle
      set_mode(1'b0, 1'b0);
      wr_tx(8'hA5); seln = 1'b0; tick(6); s = '0;
      run_bits(8'h3C, 7, 0, s);
      chk(rxd == 8'h3C && s == 8'hA5, "R5 first byte", {rxd, s}, 16'h3CA5);
      rd_ack(); d0 = done_cnt;
      run_bits(8'hF0, 7, 0, s);
      chk(done_cnt == d0, "R5 no restart", done_cnt, d0);
      chk(rxd == 8'h3C, "R5 rx held", rxd, 8'h3C);
      seln = 1'b1; tick(4);

      // R6 phase 0 ignores the select-ignore option
      set_mode(1'b1, 1'b0);
      sig = 1'b1; tick(6);
      chk(dout_oe == 0, "R6 oe low", dout_oe, 0);
      d0 = done_cnt;
      run_bits(8'h81, 7, 0, s);
      chk(done_cnt == d0, "R6 no byte", done_cnt, d0);
      sig = 1'b0;

      // R7 phase 1, select low across two bytes
      set_mode(1'b1, 1'b1);
      wr_tx(8'h5A); seln = 1'b0; tick(6); s = '0;
      run_bits(8'hC3, 7, 0, s);
      chk(rxd == 8'hC3 && s == 8'h5A, "R7 byte one", {rxd, s}, 16'hC35A);
      rd_ack(); wr_tx(8'h96); s = '0;
      run_bits(8'h69, 7, 0, s);
      chk(rxd == 8'h69 && s == 8'h96, "R7 byte two", {rxd, s}, 16'h6996);
      rd_ack();

      // R9 aborted byte, then clean byte
      d0 = done_cnt; s = '0;
      run_bits(8'hFF, 7, 4, s);
      seln = 1'b1; tick(6);
      chk(dout_oe == 0, "R9 oe released", dout_oe, 0);
      chk(done_cnt == d0, "R9 no done", done_cnt, d0);
      seln = 1'b0; tick(6); s = '0;
      run_bits(8'h2D, 7, 0, s);
      chk(rxd == 8'h2D && done_cnt == d0 + 1, "R9 realign", rxd, 8'h2D);
      rd_ack();

      // R8 late write inside a byte
      t = 8'h11; t2 = 8'hE7; wr_tx(t); s = '0;
      run_bits(8'h44, 7, 4, s);
      wr_tx(t2);
      run_bits(8'h44, 3, 0, s);
      chk(lerr == 1, "R8 late flag", lerr, 1);
      chk(s == t, "R8 current byte", s, t);
      rd_ack(); s = '0;
      run_bits(8'h00, 7, 0, s);
      chk(s == t2, "R8 deferred byte", s, t2);
      rd_ack();

      // R11 enable low clears flags
      en = 1'b0; tick(2);
      chk(lerr == 0 && oerr == 0, "R11 flags", {lerr, oerr}, 0);
      chk(dout_oe == 0, "R11 oe", dout_oe, 0);
      en = 1'b1; tick(2);

      // R10 overrun
      hold = 8'h77; s = '0;
      run_bits(hold, 7, 0, s);
      chk(oerr == 0, "R10 first ok", oerr, 0);
      run_bits(8'h9E, 7, 0, s);
      chk(oerr == 1, "R10 overrun", oerr, 1);
      chk(rxd == 8'h9E, "R10 overwrite", rxd, 8'h9E);
      seln = 1'b1; tick(4);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule